// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Two-Way Cache Lookup

This block is the lookup path of a small write-back data cache. The cache has two ways, 128 sets and 32-byte lines, for 8 KB in total. The set is chosen from untranslated bits of the virtual address. At the same time, an 8-entry fully associative translation buffer maps the virtual page number to a 26-bit physical page number. That page number is then compared against the physical tags of both ways in the selected set.

Set index and byte offset together cover the low 12 bits of the address. This is exactly the 4 KB page offset, so those bits are identical in the virtual and physical address. As a result, two virtual pages that map to the same physical page always land on the same cached line.

The CPU side is a valid/ready request port with a one-cycle response strobe. A translation miss is raised on a refill port and held until the page number arrives. A line miss uses a single request channel to the next level:
- a write request carries the dirty victim, when there is one;
- a read request follows, and the line then returns on a fill strobe.

After any refill or fill, the request is replayed internally.

Top module: `vipt_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `tlb_miss` and `mem_req_valid` are 0, with no line and no translation valid.
- R2: The set index is vaddr[11:5] and the word select is vaddr[4:2]. The physical address is {PPN, vaddr[11:0]}. Every line request address is {tag or PPN, set, 5'b0}.
- R3: A request whose page is not translated raises `tlb_miss` with `tlb_miss_vpn` = vaddr[31:12]. Both stay stable until `tlb_fill_valid`, and `req_ready` stays 0 meanwhile.
- R4: The translation buffer holds 8 pages and is refilled in round-robin order. A page among the last 8 refilled does not miss again; the 9th refill evicts the oldest.
- R5: A load that hits in both the translation buffer and the cache raises `resp_valid` in the cycle after acceptance, with the addressed 32-bit word on `resp_rdata`.
- R6: A store hit replaces only the bytes whose `req_be` bit is 1 (bit n is data bits 8n+7..8n). It responds in the cycle after acceptance and marks the line dirty.
- R7: A miss whose victim is clean issues exactly one read request (`mem_req_write`=0) and no write request, then completes from the filled line.
- R8: The victim is way 0 if invalid, else way 1 if invalid, else the way not used most recently in that set.
- R9: A dirty victim is sent as a write request at {its tag, set, 5'b0} with its line data before the read request for the new line, and its data is preserved in the next level.
- R10: `req_ready` is 0 from acceptance until the response, and `resp_valid` is high for exactly one cycle per request.
- R11: Two virtual pages mapped to the same physical page share one cached line. An access through the second page hits without line traffic and sees stores made through the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| resp_valid | output | 1 | Request completed this cycle |
| resp_rdata | output | 32 | Load data |
| tlb_miss | output | 1 | Translation needed |
| tlb_miss_vpn | output | 20 | Page number to translate |
| tlb_fill_valid | input | 1 | Translation supplied |
| tlb_fill_ppn | input | 26 | Physical page number supplied |
| mem_req_valid | output | 1 | Line request to next level |
| mem_req_ready | input | 1 | Line request accepted |
| mem_req_write | output | 1 | 1 = victim write, 0 = line read |
| mem_req_addr | output | 38 | Line-aligned physical address |
| mem_req_wdata | output | 256 | Victim line data |
| mem_fill_valid | input | 1 | Read line returned |
| mem_fill_data | input | 256 | Returned line data |

## Verification
The hardest situation to reach from the ports is a dirty victim chosen by the recency bit while both ways are valid. It needs three distinct physical tags in one set, a store, and a chosen order of hits. A directed sequence sets this up, and the evicted data is proven by reading it back after a further miss.

Synonyms are created by giving the bench page table one extra virtual page that maps onto an already-cached physical page. Round-robin translation eviction is shown by counting refills across nine pages.

A long arithmetic sweep then mixes loads and stores over twelve pages and all sets against a word-level memory model.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOK  = 3'd1,
        ST_XLATE = 3'd2,
        ST_EVICT = 3'd3,
        ST_FREQ  = 3'd4,
        ST_FWAIT = 3'd5
    } cache_st_e;
endpackage

// File: rtl/vipt_xlate_buf.sv
module vipt_xlate_buf #(
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 26,
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [PTR_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = vld_q[e] && (vpn_q[e] == lk_vpn);
    end

    always_comb begin
        lk_hit = |match;
        lk_ppn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) lk_ppn = lk_ppn | ppn_q[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                vpn_q[e] <= '0;
                ppn_q[e] <= '0;
            end
        end else if (fill_en) begin
            vld_q[ptr_q] <= 1'b1;
            vpn_q[ptr_q] <= fill_vpn;
            ppn_q[ptr_q] <= fill_ppn;
            ptr_q        <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
    parameter int WAYS   = 2,
    parameter int SET_W  = 7,
    parameter int TAG_W  = 26,
    parameter int LINE_W = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0][LINE_W-1:0] rd_data,
    output logic                        rd_lru,
    input  logic                        wr_en,
    input  logic                        wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [LINE_W-1:0]           wr_data,
    input  logic                        wr_dirty,
    input  logic                        touch_en,
    input  logic                        touch_way
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]  tag_q [SETS];
        logic [LINE_W-1:0] dat_q [SETS];
        logic [SETS-1:0]   vld_q;
        logic [SETS-1:0]   drt_q;
        logic              sel;

        assign sel = wr_en && (wr_way == 1'(w));

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[rd_set] <= wr_tag;
                dat_q[rd_set] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
                drt_q <= '0;
            end else if (sel) begin
                vld_q[rd_set] <= 1'b1;
                drt_q[rd_set] <= wr_dirty;
            end
        end

        assign rd_valid[w] = vld_q[rd_set];
        assign rd_dirty[w] = drt_q[rd_set];
        assign rd_tag[w]   = tag_q[rd_set];
        assign rd_data[w]  = dat_q[rd_set];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lru_q <= '0;
        else if (touch_en) lru_q[rd_set] <= ~touch_way;
    end

    assign rd_lru = lru_q[rd_set];
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_cache_pkg::*;
#(
    parameter  int VPN_W  = 20,
    parameter  int PPN_W  = 26,
    parameter  int SET_W  = 7,
    parameter  int OFS_W  = 5,
    parameter  int TLB_N  = 8,
    localparam int VA_W   = VPN_W + SET_W + OFS_W,
    localparam int PA_W   = PPN_W + SET_W + OFS_W,
    localparam int LINE_W = 8 << OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              tlb_miss,
    output logic [VPN_W-1:0]  tlb_miss_vpn,
    input  logic              tlb_fill_valid,
    input  logic [PPN_W-1:0]  tlb_fill_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_fill_valid,
    input  logic [LINE_W-1:0] mem_fill_data
);
    localparam int WAYS  = 2;
    localparam int WSEL_W = OFS_W - 2;

    typedef struct packed {
        cache_st_e       st;
        logic            we;
        logic [VA_W-1:0] va;
        logic [31:0]     wd;
        logic [3:0]      be;
        logic            vic;
    } regs_t;

    regs_t r_d, r_q;

    logic [VPN_W-1:0]            vpn;
    logic [SET_W-1:0]            set_idx;
    logic [WSEL_W-1:0]           wsel;
    logic                        tb_hit;
    logic [PPN_W-1:0]            tb_ppn;
    logic [WAYS-1:0]             rd_valid, rd_dirty, way_hit;
    logic [WAYS-1:0][PPN_W-1:0]  rd_tag;
    logic [WAYS-1:0][LINE_W-1:0] rd_data;
    logic                        rd_lru, hit, hw, victim;
    logic [LINE_W-1:0]           hit_line, merged;
    logic                        wr_en, wr_way, wr_dirty, touch_en;
    logic [LINE_W-1:0]           wr_data;

    assign vpn     = r_q.va[VA_W-1 -: VPN_W];
    assign set_idx = r_q.va[OFS_W +: SET_W];
    assign wsel    = r_q.va[OFS_W-1:2];

    vipt_xlate_buf #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(TLB_N)) u_xlate (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(vpn), .lk_hit(tb_hit), .lk_ppn(tb_ppn),
        .fill_en(r_q.st == ST_XLATE && tlb_fill_valid),
        .fill_vpn(vpn), .fill_ppn(tlb_fill_ppn)
    );

    vipt_line_store #(.WAYS(WAYS), .SET_W(SET_W), .TAG_W(PPN_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(set_idx),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_data(rd_data),
        .rd_lru(rd_lru),
        .wr_en(wr_en), .wr_way(wr_way), .wr_tag(tb_ppn), .wr_data(wr_data),
        .wr_dirty(wr_dirty), .touch_en(touch_en), .touch_way(hw)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_hit
        assign way_hit[w] = tb_hit && rd_valid[w] && (rd_tag[w] == tb_ppn);
    end

    always_comb begin
        r_d      = r_q;
        hit      = |way_hit;
        hw       = way_hit[1];
        hit_line = rd_data[hw];
        merged   = hit_line;
        for (int b = 0; b < 4; b++) begin
            if (r_q.be[b]) merged[int'(wsel)*32 + b*8 +: 8] = r_q.wd[b*8 +: 8];
        end
        victim = !rd_valid[0] ? 1'b0 : (!rd_valid[1] ? 1'b1 : rd_lru);

        req_ready     = (r_q.st == ST_IDLE);
        resp_valid    = (r_q.st == ST_LOOK) && hit;
        resp_rdata    = hit_line[int'(wsel)*32 +: 32];
        tlb_miss      = (r_q.st == ST_XLATE);
        tlb_miss_vpn  = vpn;
        mem_req_valid = (r_q.st == ST_EVICT) || (r_q.st == ST_FREQ);
        mem_req_write = (r_q.st == ST_EVICT);
        mem_req_addr  = {(r_q.st == ST_EVICT) ? rd_tag[r_q.vic] : tb_ppn, set_idx, OFS_W'(0)};
        mem_req_wdata = rd_data[r_q.vic];

        wr_en    = 1'b0;
        wr_way   = r_q.vic;
        wr_data  = mem_fill_data;
        wr_dirty = 1'b0;
        touch_en = (r_q.st == ST_LOOK) && hit;

        unique case (r_q.st)
            ST_IDLE: if (req_valid) begin
                r_d.st = ST_LOOK;
                r_d.we = req_we;
                r_d.va = req_vaddr;
                r_d.wd = req_wdata;
                r_d.be = req_be;
            end
            ST_LOOK: begin
                if (!tb_hit) begin
                    r_d.st = ST_XLATE;
                end else if (hit) begin
                    r_d.st   = ST_IDLE;
                    wr_en    = r_q.we;
                    wr_way   = hw;
                    wr_data  = merged;
                    wr_dirty = 1'b1;
                end else begin
                    r_d.vic = victim;
                    r_d.st  = (rd_valid[victim] && rd_dirty[victim]) ? ST_EVICT : ST_FREQ;
                end
            end
            ST_XLATE: if (tlb_fill_valid) r_d.st = ST_LOOK;
            ST_EVICT: if (mem_req_ready)  r_d.st = ST_FREQ;
            ST_FREQ:  if (mem_req_ready)  r_d.st = ST_FWAIT;
            ST_FWAIT: if (mem_fill_valid) begin
                wr_en  = 1'b1;
                r_d.st = ST_LOOK;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
    parameter int VPN_W = 20,
    parameter int PA_W  = 38
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             tlb_miss,
    input logic [VPN_W-1:0] tlb_miss_vpn,
    input logic             tlb_fill_valid,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_write,
    input logic [PA_W-1:0]  mem_req_addr
);
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);                                       // R10
    AST_RESP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);                                        // R10
    AST_XLATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_miss |-> !req_ready);                                          // R3
    AST_XLATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_miss && !tlb_fill_valid |=> tlb_miss && $stable(tlb_miss_vpn)); // R3
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[4:0] == 5'd0);                      // R2
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                            && $stable(mem_req_write));    // R9
    AST_EVICT_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready && mem_req_write |=> mem_req_valid && !mem_req_write); // R9
    AST_ONE_MISS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(tlb_miss && mem_req_valid));                                     // R7
endmodule

bind vipt_cache vipt_cache_chk #(.VPN_W(VPN_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
    .tlb_miss(tlb_miss), .tlb_miss_vpn(tlb_miss_vpn), .tlb_fill_valid(tlb_fill_valid),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr)
);

// File: tb/vipt_cache_bench.sv
`timescale 1ns/1ps
module vipt_cache_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_we = 1'b0;
    logic [31:0]  req_vaddr = '0, req_wdata = '0;
    logic [3:0]   req_be = '0;
    logic         req_ready, resp_valid;
    logic [31:0]  resp_rdata;
    logic         tlb_miss;
    logic [19:0]  tlb_miss_vpn;
    logic         tlb_fill_valid = 1'b0;
    logic [25:0]  tlb_fill_ppn = '0;
    logic         mem_req_valid, mem_req_write;
    logic         mem_req_ready = 1'b0;
    logic [37:0]  mem_req_addr;
    logic [255:0] mem_req_wdata;
    logic         mem_fill_valid = 1'b0;
    logic [255:0] mem_fill_data = '0;

    always #2.5 clk = ~clk;

    vipt_cache u_vipt_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_vaddr(req_vaddr), .req_wdata(req_wdata), .req_be(req_be),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .tlb_miss(tlb_miss), .tlb_miss_vpn(tlb_miss_vpn),
        .tlb_fill_valid(tlb_fill_valid), .tlb_fill_ppn(tlb_fill_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_fill_valid(mem_fill_valid),
        .mem_fill_data(mem_fill_data)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int n_tlb = 0, n_rd = 0, n_wb = 0, seq = 0, rd_seq = 0, wb_seq = 0, bad_ready = 0;
    logic [19:0]  last_vpn;
    logic [37:0]  last_rd_addr, last_wb_addr;
    logic [255:0] mem_q [logic [32:0]];
    logic [31:0]  exp_q [logic [35:0]];
    logic         pend = 1'b0;
    logic [32:0]  pend_la;

    localparam logic [19:0] SYN_VPN = 20'hFFFFF;

    function automatic logic [25:0] pt(input logic [19:0] vpn);
        logic [19:0] v;
        v = (vpn == SYN_VPN) ? 20'h00010 : vpn;
        return {6'h2B, v ^ 20'h3C3C3};
    endfunction

    function automatic logic [37:0] pa_of(input logic [31:0] va);
        return {pt(va[31:12]), va[11:0]};
    endfunction

    function automatic logic [31:0] init_word(input logic [35:0] wa);
        logic [35:0] m;
        m = wa * 36'd2654435761;
        return m[31:0] ^ 32'h5A5A0000;
    endfunction

    function automatic logic [255:0] line_at(input logic [32:0] la);
        logic [255:0] l;
        if (mem_q.exists(la)) return mem_q[la];
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = init_word({la, 3'(i)});
        return l;
    endfunction

    function automatic logic [31:0] exp_word(input logic [35:0] wa);
        return exp_q.exists(wa) ? exp_q[wa] : init_word(wa);
    endfunction

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // translation responder
    initial forever begin
        @(negedge clk);
        if (tlb_miss && !tlb_fill_valid) begin
            tlb_fill_valid = 1'b1;
            tlb_fill_ppn   = pt(tlb_miss_vpn);
            last_vpn       = tlb_miss_vpn;
            n_tlb++;
        end else begin
            tlb_fill_valid = 1'b0;
        end
    end

    // next-level memory responder
    initial forever begin
        @(negedge clk);
        mem_fill_valid = 1'b0;
        if (pend) begin
            mem_fill_valid = 1'b1;
            mem_fill_data  = line_at(pend_la);
            pend = 1'b0;
        end
        if (mem_req_ready) begin
            mem_req_ready = 1'b0;
        end else if (mem_req_valid) begin
            mem_req_ready = 1'b1;
            seq++;
            if (mem_req_write) begin
                mem_q[mem_req_addr[37:5]] = mem_req_wdata;
                n_wb++; wb_seq = seq; last_wb_addr = mem_req_addr;
            end else begin
                pend = 1'b1; pend_la = mem_req_addr[37:5];
                n_rd++; rd_seq = seq; last_rd_addr = mem_req_addr;
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] va, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output int cyc);
        logic [35:0] wa;
        logic [31:0] w;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_vaddr = va; req_wdata = wd; req_be = be;
        @(posedge clk);
        cyc = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
            if (req_ready) bad_ready++;
        end while (!resp_valid && cyc < 2000);
        rd = resp_rdata;
        if (we) begin
            wa = pa_of(va)[37:2];
            w  = exp_word(wa);
            for (int b = 0; b < 4; b++) if (be[b]) w[b*8 +: 8] = wd[b*8 +: 8];
            exp_q[wa] = w;
        end
    endtask

    task automatic load(input logic [31:0] va, input string r, output int cyc);
        logic [31:0] rd, e;
        access(1'b0, va, '0, '0, rd, cyc);
        e = exp_word(pa_of(va)[37:2]);
        chk(rd == e, r, rd, e);
    endtask

    task automatic store(input logic [31:0] va, input logic [31:0] wd, input logic [3:0] be, output int cyc);
        logic [31:0] rd;
        access(1'b1, va, wd, be, rd, cyc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    localparam logic [31:0] VA0 = {20'h00010, 7'd3, 5'd8};

    initial begin
        int c, rdb, tb0;
        logic [31:0] lcg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid && !tlb_miss && !mem_req_valid, "R1",
            {req_ready, resp_valid, tlb_miss, mem_req_valid}, 4'b1000);

        // R3 R7 R2: cold load
        load(VA0, "R7", c);
        chk(n_tlb == 1, "R3", n_tlb, 1);
        chk(last_vpn == 20'h00010, "R3", last_vpn, 20'h00010);
        chk(n_rd == 1 && n_wb == 0, "R7", {n_rd, n_wb}, {32'd1, 32'd0});
        chk(last_rd_addr == {pt(20'h00010), 7'd3, 5'd0}, "R2", last_rd_addr, {pt(20'h00010), 7'd3, 5'd0});

        // R5: hit on another word of the same line
        load(VA0 + 32'd12, "R5", c);
        chk(c == 1, "R5", c, 1);
        chk(n_rd == 1, "R5", n_rd, 1);

        // R6: partial store hit
        store(VA0, 32'hDEADBEEF, 4'b0101, c);
        chk(c == 1, "R6", c, 1);
        load(VA0, "R6", c);

        // R8: second tag fills the invalid way, first stays
        load({20'h00020, 7'd3, 5'd0}, "R8", c);
        chk(n_rd == 2 && n_wb == 0, "R8", {n_rd, n_wb}, {32'd2, 32'd0});
        load(VA0, "R8", c);
        chk(c == 1, "R8", c, 1);
        // third tag evicts the least recently used clean way
        load({20'h00030, 7'd3, 5'd0}, "R8", c);
        chk(n_wb == 0, "R8", n_wb, 0);
        load(VA0, "R8", c);
        chk(c == 1, "R8", c, 1);
        load({20'h00020, 7'd3, 5'd0}, "R8", c);
        chk(n_wb == 0 && n_rd == 4, "R8", {n_rd, n_wb}, {32'd4, 32'd0});

        // R9: dirty line of VA0 is now least recent
        load({20'h00040, 7'd3, 5'd4}, "R9", c);
        chk(n_wb == 1, "R9", n_wb, 1);
        chk(last_wb_addr == {pt(20'h00010), 7'd3, 5'd0}, "R9", last_wb_addr, {pt(20'h00010), 7'd3, 5'd0});
        chk(rd_seq > wb_seq, "R9", rd_seq, wb_seq + 1);
        rdb = n_rd;
        load(VA0, "R9", c);
        chk(n_rd == rdb + 1, "R9", n_rd, rdb + 1);

        // R4: round-robin translation buffer
        for (int p = 5; p <= 8; p++) load({20'(p * 16), 7'd9, 5'd0}, "R4", c);
        chk(n_tlb == 8, "R4", n_tlb, 8);
        load(VA0, "R4", c);
        chk(n_tlb == 8, "R4", n_tlb, 8);
        load({20'h00090, 7'd9, 5'd0}, "R4", c);
        load(VA0, "R4", c);
        chk(n_tlb == 10, "R4", n_tlb, 10);

        // R11: synonym page
        rdb = n_rd; tb0 = n_tlb;
        load({SYN_VPN, 7'd3, 5'd8}, "R11", c);
        chk(n_rd == rdb && n_tlb == tb0 + 1, "R11", {n_rd, n_tlb}, {rdb, tb0 + 1});
        store({SYN_VPN, 7'd3, 5'd8}, 32'h0BADF00D, 4'b1010, c);
        load(VA0, "R11", c);
        chk(n_rd == rdb, "R11", n_rd, rdb);

        // sweep: mixed traffic across pages and sets
        lcg = 32'h1234567;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] va;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            va = {20'h00100 + 20'(lcg[31:28] % 12), lcg[22:16], lcg[10:8], 2'b00};
            if (lcg[5]) store(va, lcg ^ 32'hC3C3C3C3, lcg[3:0] | 4'b0001, c);
            else        load(va, "R6", c);
        end
        for (int s = 0; s < 128; s += 9) load({20'h00105, 7'(s), 5'd16}, "R9", c);

        chk(bad_ready == 0, "R10", bad_ready, 0);
        finish_run();
    end
endmodule